// File: doc/BRIEF.md
# Complementary Dead-Time PWM Generator

This block drives the two gate signals of a synchronous buck half-bridge. A free-running up-counter sweeps from zero to a programmable period value and wraps. The high-side signal turns on at the wrap and turns off when the counter meets the duty compare value. The low-side signal is the complement of the high-side signal. Each output then passes through its own turn-on delay. The high-side delay and the low-side delay are set separately, and a common prescaler scales both. The two switches are therefore never on at the same time.

The period, duty and ADC compare inputs are plain control pins. No data stream passes through the block, so it has no valid/ready handshake. These three values are captured only at the wrap. The captured duty is forced into a legal window, so the high-side pulse always ends before the period does. A one-cycle pulse tells an external converter when to sample. An output-enable pin and a fault pin each force both gate signals low at once, with no clock delay.

Top module: `dtpwm_gen`

## Requirements
- R1: After reset both gate outputs and the trigger are low. The counter reads 0, the applied duty reads MIN_DUTY (8), the applied period is RST_PERIOD (1599) and the ADC compare value is 1000.
- R2: While cnt_en_i is high, the counter steps by one each cycle from 0 to the applied period P inclusive, so one period lasts P+1 cycles. While cnt_en_i is low, the counter holds its value.
- R3: A period request below 100 is applied as 100.
- R4: A duty request below MIN_DUTY (8) is applied as MIN_DUTY.
- R5: A duty request above the duty limit is applied as the limit. The limit is max_duty_i, except that when the period exceeds 10 and max_duty_i is at least period-1, the limit is period-1.
- R6: Period, duty and ADC compare requests take effect only at the wrap, in the cycle where the counter reads 0. Between wraps, the applied values do not change.
- R7: With both dead times zero, hs_o is high for D+1 cycles of each period and ls_o is high for P-D cycles, where D is the applied duty.
- R8: hs_o turns on dt_rise_i*2^dt_pre_i cycles later than it would with zero dead time. ls_o turns on dt_fall_i*2^dt_pre_i cycles later. Turn-off is never delayed. hs_o and ls_o are never high together.
- R9: When an output's delay is at least as long as its undelayed pulse, that pulse is dropped completely.
- R10: When out_en_i is low or fault_i is high, hs_o and ls_o are both low. The counter keeps running.
- R11: adc_trig_o is high for exactly one cycle per period. That cycle is the one after the counter equals the applied ADC compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Counter run enable |
| out_en_i | input | 1 | Gate output enable for both outputs |
| fault_i | input | 1 | Forces both gate outputs low |
| period_i | input | 16 | Requested period (counter top value) |
| duty_i | input | 16 | Requested duty compare value |
| max_duty_i | input | 16 | Upper duty limit |
| adc_cmp_i | input | 16 | Requested ADC trigger compare value |
| dt_rise_i | input | 9 | High-side turn-on delay in prescaled units |
| dt_fall_i | input | 9 | Low-side turn-on delay in prescaled units |
| dt_pre_i | input | 2 | Dead-time unit is 2^dt_pre_i cycles |
| hs_o | output | 1 | High-side gate |
| ls_o | output | 1 | Low-side gate |
| adc_trig_o | output | 1 | One-cycle sampling trigger |
| cnt_o | output | 16 | Current counter value |
| duty_o | output | 16 | Applied duty after clamping |

## Verification
A wrong applied period shows on cnt_o within one period, because the wrap comes at the wrong value. A wrong applied duty shows on duty_o in the cycle it is loaded, and it also changes the hs_o/ls_o cycle counts in the next period. A dead-time counter that holds the wrong state changes the on-time of its output within one period, and it can make the two gates high together. The bench counts the high cycles of each output over whole periods after the settings have settled, and it checks for overlap in every cycle.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
  parameter int CNT_W = 16;
  parameter int DT_W  = 9;
  parameter int PRE_W = 2;
  // widest delay: dead time shifted by the largest prescale
  parameter int DLY_W = DT_W + (1 << PRE_W) - 1;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [DLY_W-1:0] dly_t;

  typedef struct packed {
    cnt_t period;
    cnt_t duty;
    cnt_t adc;
  } shadow_t;
endpackage

// File: rtl/dtpwm_timebase.sv
module dtpwm_timebase
  import dtpwm_pkg::*;
#(
  parameter cnt_t MIN_DUTY   = cnt_t'(8),
  parameter cnt_t MIN_PERIOD = cnt_t'(100),
  parameter cnt_t RST_PERIOD = cnt_t'(1599),
  parameter cnt_t RST_ADC    = cnt_t'(1000)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_en_i,
  input  cnt_t period_i,
  input  cnt_t duty_i,
  input  cnt_t max_duty_i,
  input  cnt_t adc_cmp_i,
  output cnt_t cnt_o,
  output cnt_t duty_o,
  output logic hs_raw_o,
  output logic adc_trig_o
);
  localparam cnt_t SMALL_PER = cnt_t'(10);
  localparam cnt_t ONE       = cnt_t'(1);

  cnt_t    cnt_q;
  shadow_t act_q, req;
  cnt_t    lim;
  logic    pev;
  logic    hs_q, trig_q;

  assign pev = cnt_en_i && (cnt_q == act_q.period);

  // clamp the requested values against the period being loaded
  always_comb begin
    req.period = (period_i < MIN_PERIOD) ? MIN_PERIOD : period_i;
    lim = max_duty_i;
    if (req.period > SMALL_PER && lim >= req.period - ONE) lim = req.period - ONE;
    if (duty_i < MIN_DUTY)  req.duty = MIN_DUTY;
    else if (duty_i > lim)  req.duty = lim;
    else                    req.duty = duty_i;
    req.adc = adc_cmp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      act_q  <= '{period: RST_PERIOD, duty: MIN_DUTY, adc: RST_ADC};
      hs_q   <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= cnt_en_i && (cnt_q == act_q.adc);
      if (cnt_en_i) begin
        if (pev) begin
          cnt_q <= '0;
          act_q <= req;
          hs_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + ONE;
          if (cnt_q == act_q.duty) hs_q <= 1'b0;
        end
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign duty_o     = act_q.duty;
  assign hs_raw_o   = hs_q;
  assign adc_trig_o = trig_q;

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !pev) |=> (cnt_q == $past(cnt_q) + ONE));
  a_r2_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(cnt_q));
  a_r3_period_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q.period >= MIN_PERIOD);
  a_r5_duty_below_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q.duty < act_q.period);
  a_r6_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pev |=> ($stable(act_q.duty) && $stable(act_q.period) && $stable(act_q.adc)));
  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> !trig_q);
endmodule

// File: rtl/dtpwm_deadband.sv
module dtpwm_deadband
  import dtpwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  dly_t dly_i,
  output logic out_o
);
  dly_t held_q;
  logic out_q;

  // turn-on waits until raw has been high for dly_i cycles; turn-off is immediate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      out_q  <= 1'b0;
    end else if (!raw_i) begin
      held_q <= '0;
      out_q  <= 1'b0;
    end else begin
      out_q <= (held_q >= dly_i);
      if (held_q < dly_i) held_q <= held_q + dly_t'(1);
    end
  end

  assign out_o = out_q;

  a_r9_no_sliver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw_i |=> !out_q);
endmodule

// File: rtl/dtpwm_gen.sv
module dtpwm_gen
  import dtpwm_pkg::*;
#(
  parameter cnt_t MIN_DUTY   = cnt_t'(8),
  parameter cnt_t MIN_PERIOD = cnt_t'(100),
  parameter cnt_t RST_PERIOD = cnt_t'(1599),
  parameter cnt_t RST_ADC    = cnt_t'(1000)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             out_en_i,
  input  logic             fault_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] max_duty_i,
  input  logic [CNT_W-1:0] adc_cmp_i,
  input  logic [DT_W-1:0]  dt_rise_i,
  input  logic [DT_W-1:0]  dt_fall_i,
  input  logic [PRE_W-1:0] dt_pre_i,
  output logic             hs_o,
  output logic             ls_o,
  output logic             adc_trig_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] duty_o
);
  localparam int N_LEG = 2;

  logic               hs_raw;
  logic [N_LEG-1:0]   leg_raw, leg_out;
  logic [DT_W-1:0]    leg_dt [N_LEG];
  dly_t               leg_dly [N_LEG];
  logic               gate_ok;

  dtpwm_timebase #(
    .MIN_DUTY(MIN_DUTY), .MIN_PERIOD(MIN_PERIOD),
    .RST_PERIOD(RST_PERIOD), .RST_ADC(RST_ADC)
  ) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i),
    .period_i(period_i), .duty_i(duty_i), .max_duty_i(max_duty_i),
    .adc_cmp_i(adc_cmp_i), .cnt_o(cnt_o), .duty_o(duty_o),
    .hs_raw_o(hs_raw), .adc_trig_o(adc_trig_o)
  );

  // leg 0 is the high side, leg 1 the low side
  assign leg_raw = {~hs_raw, hs_raw};
  assign leg_dt[0] = dt_rise_i;
  assign leg_dt[1] = dt_fall_i;

  for (genvar g = 0; g < N_LEG; g++) begin : g_leg
    assign leg_dly[g] = dly_t'(leg_dt[g]) << dt_pre_i;
    dtpwm_deadband u_db (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(leg_raw[g]),
      .dly_i(leg_dly[g]), .out_o(leg_out[g])
    );
  end

  assign gate_ok = out_en_i && !fault_i;
  assign hs_o = leg_out[0] && gate_ok;
  assign ls_o = leg_out[1] && gate_ok;

  a_r8_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(leg_out[0] && leg_out[1]));
  a_r10_gate_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_en_i || fault_i) |-> (!hs_o && !ls_o));
endmodule

// File: tb/sim_dtpwm_gen.sv
module sim_dtpwm_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, out_en = 1'b0, fault = 1'b0;
  logic [15:0] period = 16'd200, duty = 16'd60, max_duty = 16'd1000, adc_cmp = 16'd40;
  logic [8:0]  dt_r = '0, dt_f = '0;
  logic [1:0]  pre = '0;
  logic        hs, ls, trig;
  logic [15:0] cnt, duty_act;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dtpwm_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .out_en_i(out_en),
    .fault_i(fault), .period_i(period), .duty_i(duty), .max_duty_i(max_duty),
    .adc_cmp_i(adc_cmp), .dt_rise_i(dt_r), .dt_fall_i(dt_f), .dt_pre_i(pre),
    .hs_o(hs), .ls_o(ls), .adc_trig_o(trig), .cnt_o(cnt), .duty_o(duty_act)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_wrap();
    do @(negedge clk); while (cnt != 0);
  endtask

  // one full period from wrap to wrap
  task automatic measure(output int len, output int nh, output int nl,
                         output int nt, output int ov, output int tcnt);
    len = 0; nh = 0; nl = 0; nt = 0; ov = 0; tcnt = -1;
    wait_wrap();
    do begin
      len++;
      if (hs) nh++;
      if (ls) nl++;
      if (hs && ls) ov++;
      if (trig) begin nt++; tcnt = int'(cnt); end
      @(negedge clk);
    end while (cnt != 0);
  endtask

  task automatic settle(output int len, output int nh, output int nl,
                        output int nt, output int ov, output int tcnt);
    wait_wrap();
    wait_wrap();
    measure(len, nh, nl, nt, ov, tcnt);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 duty", int'(duty_act), 8);
    chk("R1 hs", int'(hs), 0);
    chk("R1 ls", int'(ls), 0);
    chk("R1 trig", int'(trig), 0);
  endtask

  task automatic t_plain();
    int len, nh, nl, nt, ov, tc;
    out_en = 1'b1; cnt_en = 1'b1;
    settle(len, nh, nl, nt, ov, tc);
    chk("R2 period length", len, 201);
    chk("R7 hs on-time", nh, 61);
    chk("R7 ls on-time", nl, 140);
    chk("R8 overlap", ov, 0);
    chk("R11 trig count", nt, 1);
    chk("R11 trig position", tc, 41);
  endtask

  task automatic t_deadtime();
    int len, nh, nl, nt, ov, tc;
    dt_r = 9'd5; dt_f = 9'd3; pre = 2'd1;
    settle(len, nh, nl, nt, ov, tc);
    chk("R8 hs delayed", nh, 51);
    chk("R8 ls delayed", nl, 134);
    chk("R8 overlap", ov, 0);
    dt_r = 9'd30; dt_f = 9'd0; pre = 2'd0; duty = 16'd20;
    settle(len, nh, nl, nt, ov, tc);
    chk("R9 hs suppressed", nh, 0);
    chk("R9 ls intact", nl, 180);
    dt_r = '0; duty = 16'd60;
  endtask

  task automatic t_clamps();
    int len, nh, nl, nt, ov, tc;
    duty = 16'd2;
    settle(len, nh, nl, nt, ov, tc);
    chk("R4 min duty", int'(duty_act), 8);
    duty = 16'd300; max_duty = 16'd500;
    settle(len, nh, nl, nt, ov, tc);
    chk("R5 limit period-1", int'(duty_act), 199);
    max_duty = 16'd50; duty = 16'd80;
    settle(len, nh, nl, nt, ov, tc);
    chk("R5 limit max", int'(duty_act), 50);
    period = 16'd50; max_duty = 16'd1000; duty = 16'd60;
    settle(len, nh, nl, nt, ov, tc);
    chk("R3 period floor", len, 101);
    period = 16'd200;
    settle(len, nh, nl, nt, ov, tc);
  endtask

  task automatic t_shadow();
    do @(negedge clk); while (cnt != 5);
    duty = 16'd90;
    @(negedge clk);
    chk("R6 hold mid-period", int'(duty_act), 60);
    wait_wrap();
    chk("R6 load at wrap", int'(duty_act), 90);
    duty = 16'd60;
  endtask

  task automatic t_gating();
    int len, nh, nl, nt, ov, tc;
    fault = 1'b1;
    measure(len, nh, nl, nt, ov, tc);
    chk("R10 fault hs", nh, 0);
    chk("R10 fault ls", nl, 0);
    chk("R10 counter runs", len, 201);
    fault = 1'b0; out_en = 1'b0;
    measure(len, nh, nl, nt, ov, tc);
    chk("R10 disable hs+ls", nh + nl, 0);
    out_en = 1'b1;
  endtask

  task automatic t_hold();
    int v;
    do @(negedge clk); while (cnt != 30);
    cnt_en = 1'b0;
    @(negedge clk);
    v = int'(cnt);
    repeat (20) @(negedge clk);
    chk("R2 counter holds", int'(cnt), v);
    cnt_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_deadtime();
    t_clamps();
    t_shadow();
    t_gating();
    t_hold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule